// File: doc/BRIEF.md
# Misaligned Transfer Cycle Splitter

This block sits between a requester and a 32-bit data bus. It takes one transfer request: a byte address, a size (byte, word or doubleword) and a strobe. From that request it issues the bus cycles that carry the transfer. Each cycle has a doubleword-aligned address and an active-low four-lane byte-enable pattern. The block does not steer data and has no part in bus timing. It only decides how many cycles a transfer needs, where each cycle goes and which lanes each cycle enables.

A transfer whose bytes all fall inside one doubleword takes one cycle. A transfer that crosses a doubleword boundary takes two cycles. The cycle for the upper doubleword goes out first, and the cycle for the lower doubleword follows. A cycle stays on the outputs until the bus accepts it with `cyc_ready`. The block then moves to the next cycle, or it goes idle. The requester watches `busy` and may present a new request only while `busy` is low.

Top module: `misalign_splitter`

## Requirements
- R1: After reset, `busy`, `cyc_valid` and `cyc_last` are low and `cyc_be_n` is 4'b1111. Whenever no cycle is valid, `cyc_be_n` is 4'b1111 and `cyc_last` is low.
- R2: Sizes are encoded as follows on `req_size`: 0 is a byte, 1 is a word, and 2 or 3 is a doubleword. A byte at any offset, a word at offset 0, 1 or 2, and a doubleword at offset 0 each take one cycle. That cycle goes to the address with its two low bits cleared. Bit i of `cyc_be_n` is low exactly for the lanes that hold the transfer's bytes, starting at lane = offset.
- R3: A word at offset 3 takes two cycles. The first cycle goes to base+4 with `cyc_be_n` = 4'b1110. The second goes to base with 4'b0111.
- R4: A doubleword at offset 1 takes two cycles: base+4 with 4'b1110, then base with 4'b0001. Base+4 wraps modulo the address width.
- R5: A doubleword at offset 2 takes two cycles: base+4 with 4'b1100, then base with 4'b0011.
- R6: A doubleword at offset 3 takes two cycles: base+4 with 4'b1000, then base with 4'b0111.
- R7: Every valid cycle enables a non-empty run of adjacent lanes. A three-lane pattern appears only as one half of a split transfer.
- R8: While `cyc_valid` is high and `cyc_ready` is low, `cyc_addr`, `cyc_be_n` and `cyc_last` hold their values.
- R9: `busy` goes high on the edge that accepts a request and stays high until the edge where the last cycle is accepted. A request presented while `busy` is high is dropped and has no effect on the outputs.
- R10: `cyc_last` is high on the final cycle of a transfer and low on the first cycle of a split transfer.
- R11: The first cycle of a transfer is valid in the clock cycle right after the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | AW | Byte address of the transfer |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 doubleword |
| busy | output | 1 | A transfer is in progress |
| cyc_valid | output | 1 | A bus cycle is presented |
| cyc_addr | output | AW | Doubleword-aligned cycle address |
| cyc_be_n | output | 4 | Active-low byte-lane enables |
| cyc_last | output | 1 | This cycle is the final one of the transfer |
| cyc_ready | input | 1 | Bus accepts the presented cycle |

## Verification
The only internal state is the busy flag, the phase flag and the latched request. A wrong phase flag or a wrong latched offset shows on the very next cycle as an address that is off by four, a lane pattern that is wrong or not contiguous, or a `cyc_last` level that is wrong. If the busy flag is released early or late, the transfer either loses its second cycle or keeps a cycle valid after it was accepted. Both effects appear one edge after the acceptance that went wrong. Every transfer size and offset is therefore checked at both of its cycles, and the checks also cover stalls, requests made while busy and address wrap.

// File: rtl/misalign_splitter.sv
module misalign_splitter #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  output logic          busy,
  output logic          cyc_valid,
  output logic [AW-1:0] cyc_addr,
  output logic [3:0]    cyc_be_n,
  output logic          cyc_last,
  input  logic          cyc_ready
);
  localparam int DW = AW - 2;

  logic [DW-1:0] dw_q;
  logic [1:0]    off_q;
  logic [1:0]    size_q;
  logic          phase_q;

  logic [3:0] fill;
  logic [3:0] upper;
  logic [3:0] lower;
  logic [3:0] whole;
  logic [3:0] mask;
  logic [3:0] span;
  logic       split;

  always_comb begin
    case (size_q)
      2'd0:    fill = 4'b0001;
      2'd1:    fill = 4'b0011;
      default: fill = 4'b1111;
    endcase
  end

  assign span  = {2'b00, off_q} + (size_q[1] ? 4'd4 : (size_q[0] ? 4'd2 : 4'd1));
  assign split = span > 4'd4;

  always_comb begin
    case (span)
      4'd5:    upper = 4'b0001;
      4'd6:    upper = 4'b0011;
      4'd7:    upper = 4'b0111;
      default: upper = 4'b0000;
    endcase
  end

  assign whole = fill << off_q;
  assign lower = 4'b1111 << off_q;

  always_comb begin
    if (!busy)       mask = 4'b0000;
    else if (!split) mask = whole;
    else if (phase_q) mask = lower;
    else             mask = upper;
  end

  assign cyc_be_n  = ~mask;
  assign cyc_valid = busy;
  assign cyc_last  = busy && (!split || phase_q);
  assign cyc_addr  = {(split && !phase_q) ? dw_q + DW'(1) : dw_q, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase_q <= 1'b0;
      dw_q    <= '0;
      off_q   <= '0;
      size_q  <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy    <= 1'b1;
        phase_q <= 1'b0;
        dw_q    <= req_addr[AW-1:2];
        off_q   <= req_addr[1:0];
        size_q  <= req_size;
      end
    end else if (cyc_ready) begin
      if (split && !phase_q) phase_q <= 1'b1;
      else                   busy    <= 1'b0;
    end
  end
endmodule

module misalign_splitter_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          busy,
  input logic          cyc_valid,
  input logic [AW-1:0] cyc_addr,
  input logic [3:0]    cyc_be_n,
  input logic          cyc_last,
  input logic          cyc_ready
);
  logic seen_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_first <= 1'b0;
    else if (cyc_valid && cyc_ready) seen_first <= !cyc_last;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> (cyc_be_n == 4'b1111 && !cyc_last));

  a_r7_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> ((~cyc_be_n) inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                       4'b0011, 4'b0110, 4'b1100,
                                       4'b0111, 4'b1110, 4'b1111}));

  a_r7_three_lane_split: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && $countones(~cyc_be_n) == 3) |-> (!cyc_last || seen_first));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_addr) &&
                                   $stable(cyc_be_n) && $stable(cyc_last)));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_ready && cyc_last) |=> !busy);

  // Covers R3, R4, R5 and R6: the upper doubleword goes out before the lower one.
  a_r3_high_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_ready && !cyc_last) |=>
      (cyc_valid && cyc_last && (cyc_addr + AW'(4) == $past(cyc_addr))));

  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> cyc_valid);
endmodule

bind misalign_splitter misalign_splitter_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_misalign_splitter.sv
module sim_misalign_splitter;
  localparam int AW = 32;

  typedef struct packed {
    logic [1:0] size;
    logic [1:0] off;
    logic       two;
    logic [3:0] be1;
    logic [3:0] be2;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'd0, 2'd0, 1'b0, 4'b1110, 4'b1111},
    '{2'd0, 2'd1, 1'b0, 4'b1101, 4'b1111},
    '{2'd0, 2'd2, 1'b0, 4'b1011, 4'b1111},
    '{2'd0, 2'd3, 1'b0, 4'b0111, 4'b1111},
    '{2'd1, 2'd0, 1'b0, 4'b1100, 4'b1111},
    '{2'd1, 2'd1, 1'b0, 4'b1001, 4'b1111},
    '{2'd1, 2'd2, 1'b0, 4'b0011, 4'b1111},
    '{2'd1, 2'd3, 1'b1, 4'b1110, 4'b0111},
    '{2'd2, 2'd0, 1'b0, 4'b0000, 4'b1111},
    '{2'd2, 2'd1, 1'b1, 4'b1110, 4'b0001},
    '{2'd2, 2'd2, 1'b1, 4'b1100, 4'b0011},
    '{2'd2, 2'd3, 1'b1, 4'b1000, 4'b0111}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          cyc_ready = 1'b0;
  logic          busy, cyc_valid, cyc_last;
  logic [AW-1:0] cyc_addr;
  logic [3:0]    cyc_be_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  misalign_splitter #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .busy(busy), .cyc_valid(cyc_valid),
    .cyc_addr(cyc_addr), .cyc_be_n(cyc_be_n), .cyc_last(cyc_last),
    .cyc_ready(cyc_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (!v.two) return "R2";
    if (v.size == 2'd1) return "R3";
    case (v.off)
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic accept();
    cyc_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cyc_ready = 1'b0;
  endtask

  task automatic run_xfer(input logic [AW-1:0] addr, input vec_t v);
    logic [AW-1:0] base;
    string t;
    base = {addr[AW-1:2], 2'b00};
    t = tag_of(v);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = addr;
    req_size  = v.size;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && cyc_valid, "R11 first cycle valid", AW'(cyc_valid), AW'(1));
    chk(cyc_addr == (v.two ? base + AW'(4) : base), {t, " first addr"}, cyc_addr,
        v.two ? base + AW'(4) : base);
    chk(cyc_be_n == v.be1, {t, " first be_n"}, AW'(cyc_be_n), AW'(v.be1));
    chk(cyc_last == !v.two, "R10 first last", AW'(cyc_last), AW'(!v.two));
    accept();
    if (v.two) begin
      chk(cyc_valid && cyc_addr == base, {t, " second addr"}, cyc_addr, base);
      chk(cyc_be_n == v.be2, {t, " second be_n"}, AW'(cyc_be_n), AW'(v.be2));
      chk(cyc_last, "R10 second last", AW'(cyc_last), AW'(1));
      accept();
    end
    chk(!busy && !cyc_valid, "R9 released", AW'(busy), AW'(0));
    chk(cyc_be_n == 4'b1111, "R1 idle be_n", AW'(cyc_be_n), AW'(4'b1111));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    chk(!busy && !cyc_valid && !cyc_last, "R1 reset flags", AW'(busy), AW'(0));
    chk(cyc_be_n == 4'b1111, "R1 reset be_n", AW'(cyc_be_n), AW'(4'b1111));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy, "R1 stays idle without request", AW'(busy), AW'(0));

    for (int i = 0; i < 12; i++)
      run_xfer(32'h0000_1230 + AW'(i * 16) + AW'(VEC[i].off), VEC[i]);

    // R4 with wrap: the upper cycle lands at address 0
    run_xfer(32'hFFFF_FFFD, VEC[9]);

    // R8: stall on both halves of a doubleword at offset 2
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_4002; req_size = 2'd2;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(cyc_addr == 32'h0000_4004 && cyc_be_n == 4'b1100 && !cyc_last,
          "R8 hold first", cyc_addr, 32'h0000_4004);
    end
    accept();
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(cyc_addr == 32'h0000_4000 && cyc_be_n == 4'b0011 && cyc_last,
          "R8 hold second", cyc_addr, 32'h0000_4000);
    end
    accept();
    chk(!busy, "R8 done", AW'(busy), AW'(0));

    // R9: a request made while busy is dropped
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_5003; req_size = 2'd1;
    @(posedge clk); @(negedge clk);
    req_addr = 32'h0000_6000; req_size = 2'd0;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(cyc_addr == 32'h0000_5004 && cyc_be_n == 4'b1110, "R9 ignore while busy",
        cyc_addr, 32'h0000_5004);
    accept();
    chk(cyc_addr == 32'h0000_5000 && cyc_be_n == 4'b0111, "R9 second unaffected",
        cyc_addr, 32'h0000_5000);
    accept();
    @(negedge clk);
    chk(!busy && !cyc_valid, "R9 dropped request not queued", AW'(busy), AW'(0));

    // R7: a three-lane pattern only shows up inside a split
    v = VEC[11];
    run_xfer(32'h0000_7003, v);
    chk(v.be1 == 4'b1000 && v.two, "R7 three lanes inside split", AW'(v.be1),
        AW'(4'b1000));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule